// File: doc/BRIEF.md
# In-Order Retirement Buffer

This block keeps program order for a dynamically scheduled core. The issue stage reserves a slot for each instruction and receives the slot number as a tag. Execution units may finish in any order. A finishing unit posts its result against that tag, and the slot keeps the result until the slot becomes the oldest one in flight. Issue logic can read any slot by tag, which lets a consumer take a value that is finished but not yet retired.

Retirement happens only at the oldest end of the buffer, and up to two slots can retire in one clock. A retiring register operation drives a register-file write port. A retiring store drives a memory write port. A branch writes nothing. Two events empty the whole buffer and are acted on only when the slot that carries them is the oldest one: a branch found to be mispredicted, or a slot flagged with a fault. A mispredicted branch also sends out the address of the correct path. As a result, no architectural state is ever touched on behalf of a slot that an older branch or fault later cancels.

Top module: `rob_core`

## Requirements
- R1: The kind code on `alloc_kind` is 0 for a register-writing operation, 1 for a store and 2 for a branch. Code 3 retires without any write. A register op retires with its destination used as the register index. A store retires with its destination used as the memory address.
- R2: `alloc_grant` is high exactly when `alloc_req` and `rs_free` are high, fewer than 8 slots are occupied at the start of the cycle, and no flush happens in that cycle. `alloc_tag` is the slot index. Tags are handed out in increasing order modulo 8, starting at 0 after reset.
- R3: A result broadcast to an occupied slot stores `cdb_value` and `cdb_exc` in that slot and marks it complete. Store data arrives the same way.
- R4: A branch resolution to an occupied slot marks the slot complete, records the mispredict flag and records `br_target` as the slot's value.
- R5: Only the oldest slot may retire, and only once it is complete. A register op raises `reg_wr_en[0]` with its destination and value. A store raises `mem_wr_en[0]` with its destination as the address and its value as the data. A branch that was predicted correctly retires with no write.
- R6: A slot that is not the oldest, or not complete, causes no register or memory write.
- R7: The second-oldest slot retires in the same cycle on lane 1 when all of these hold: the oldest slot retires normally, the second slot is complete, the second slot has no fault, and the second slot is not a mispredicted branch.
- R8: When the oldest slot is a complete, mispredicted branch, `flush` is high, `redirect_pc` equals its target and nothing is written. The buffer is empty on the next cycle, so the next tag is 0.
- R9: A fault flag is raised only when its slot is the oldest and complete. In that cycle `exc_raise` and `flush` are high, `exc_tag` names the slot, `redirect_pc` is 0, nothing is written and the buffer empties.
- R10: `lookup_ready` is high only when the slot at `lookup_tag` is occupied and complete. While it is high, `lookup_value` holds that slot's value.
- R11: An allocation request in a flush cycle is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Issue wants a slot |
| alloc_kind | input | 2 | Kind code of the new instruction |
| alloc_dest | input | 16 | Register index or memory address |
| rs_free | input | 1 | A reservation station is available |
| alloc_grant | output | 1 | Slot reserved this cycle |
| alloc_tag | output | 3 | Index of the reserved slot |
| cdb_valid | input | 1 | Result broadcast valid |
| cdb_tag | input | 3 | Slot the result belongs to |
| cdb_value | input | 32 | Result or store data |
| cdb_exc | input | 1 | Result carries a fault |
| br_valid | input | 1 | Branch resolution valid |
| br_tag | input | 3 | Slot of the branch |
| br_mispredict | input | 1 | Prediction was wrong |
| br_target | input | 32 | Correct successor address |
| lookup_tag | input | 3 | Slot to read for operands |
| lookup_value | output | 32 | Value of that slot |
| lookup_ready | output | 1 | That slot holds a finished value |
| reg_wr_en | output | 2 | Register write per retire lane |
| reg_wr_idx | output | 2x16 | Register index per lane |
| reg_wr_data | output | 2x32 | Register data per lane |
| mem_wr_en | output | 2 | Memory write per retire lane |
| mem_wr_addr | output | 2x16 | Memory address per lane |
| mem_wr_data | output | 2x32 | Memory data per lane |
| flush | output | 1 | Buffer emptied this cycle |
| redirect_pc | output | 32 | Correct fetch address during a branch flush |
| exc_raise | output | 1 | Fault taken at the oldest slot |
| exc_tag | output | 3 | Slot that faulted |

## Verification
Two kinds of overlap matter here. Allocation and retirement can fall in the same cycle, and so can a flush at the oldest slot and a fresh allocation request. The bench provokes the first by keeping requests up while results arrive against a full buffer. It provokes the second by asserting a request in the very cycle a mispredicted branch reaches the oldest position. A behavioural queue model then judges, every clock, the grant and tag, both retire lanes, the flush and redirect, and the lookup port. A long random phase mixes results, branch outcomes, faults and requests, so that dual retirement, held-back faults and full-buffer stalls all coincide with issue.

// File: rtl/rob_pkg.sv
package rob_pkg;

    typedef enum logic [1:0] {
        KIND_REG    = 2'd0,
        KIND_STORE  = 2'd1,
        KIND_BRANCH = 2'd2,
        KIND_NONE   = 2'd3
    } rob_kind_e;

    localparam int unsigned RETIRE_LANES = 2;

endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned PTR_W = $clog2(DEPTH),
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_fire,
    input  logic [1:0]       retire_cnt,
    input  logic             flush,
    output logic [PTR_W-1:0] head_o,
    output logic [PTR_W-1:0] tail_o,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] tail;
        logic [CNT_W-1:0] count;
    } ptr_state_t;

    ptr_state_t st_d, st_q;

    function automatic logic [PTR_W-1:0] wrap_add(input logic [PTR_W-1:0] p,
                                                  input logic [1:0] n);
        logic [PTR_W:0] s;
        s = {1'b0, p} + (PTR_W+1)'(n);
        if (s >= (PTR_W+1)'(DEPTH)) begin
            s = s - (PTR_W+1)'(DEPTH);
        end
        return s[PTR_W-1:0];
    endfunction

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            st_d.head  = wrap_add(st_q.head, retire_cnt);
            st_d.tail  = wrap_add(st_q.tail, {1'b0, alloc_fire});
            st_d.count = st_q.count + CNT_W'(alloc_fire) - CNT_W'(retire_cnt);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_o  = st_q.head;
    assign tail_o  = st_q.tail;
    assign count_o = st_q.count;

    // R2: occupancy never exceeds the slot count
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= FULL_CNT);

    // R5: the retire stage never frees more slots than are occupied
    a_r5_retire_within_count: assert property (@(posedge clk) disable iff (!rst_n)
        CNT_W'(retire_cnt) <= st_q.count);

endmodule

// File: rtl/rob_entries.sv
module rob_entries
    import rob_pkg::*;
#(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned PTR_W  = $clog2(DEPTH),
    parameter int unsigned DEST_W = 16,
    parameter int unsigned DATA_W = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               alloc_fire,
    input  logic [PTR_W-1:0]                   alloc_idx,
    input  rob_kind_e                          alloc_kind,
    input  logic [DEST_W-1:0]                  alloc_dest,
    input  logic                               cdb_valid,
    input  logic [PTR_W-1:0]                   cdb_tag,
    input  logic [DATA_W-1:0]                  cdb_value,
    input  logic                               cdb_exc,
    input  logic                               br_valid,
    input  logic [PTR_W-1:0]                   br_tag,
    input  logic                               br_mispredict,
    input  logic [DATA_W-1:0]                  br_target,
    input  logic [1:0]                         retire_cnt,
    input  logic [PTR_W-1:0]                   head_idx,
    input  logic                               flush,
    input  logic [PTR_W-1:0]                   lk_tag,
    output logic [DATA_W-1:0]                  lk_value,
    output logic                               lk_ready,
    output logic [RETIRE_LANES-1:0]            h_valid,
    output logic [RETIRE_LANES-1:0]            h_ready,
    output logic [RETIRE_LANES-1:0]            h_exc,
    output logic [RETIRE_LANES-1:0]            h_misp,
    output rob_kind_e [RETIRE_LANES-1:0]       h_kind,
    output logic [RETIRE_LANES-1:0][DEST_W-1:0] h_dest,
    output logic [RETIRE_LANES-1:0][DATA_W-1:0] h_value
);

    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic              valid;
        logic              ready;
        logic              exc;
        logic              misp;
        rob_kind_e         kind;
        logic [DEST_W-1:0] dest;
        logic [DATA_W-1:0] value;
    } slot_t;

    slot_t [DEPTH-1:0] slot_d, slot_q;
    logic  [RETIRE_LANES-1:0][PTR_W-1:0] lane_idx;

    assign lane_idx[0] = head_idx;
    assign lane_idx[1] = (head_idx == LAST_IDX) ? '0 : head_idx + PTR_W'(1);

    always_comb begin
        slot_d = slot_q;
        for (int l = 0; l < RETIRE_LANES; l++) begin
            if (l < int'(retire_cnt)) begin
                slot_d[lane_idx[l]].valid = 1'b0;
            end
        end
        if (cdb_valid && slot_q[cdb_tag].valid) begin
            slot_d[cdb_tag].value = cdb_value;
            slot_d[cdb_tag].ready = 1'b1;
            slot_d[cdb_tag].exc   = cdb_exc;
        end
        if (br_valid && slot_q[br_tag].valid) begin
            slot_d[br_tag].value = br_target;
            slot_d[br_tag].ready = 1'b1;
            slot_d[br_tag].misp  = br_mispredict;
        end
        if (alloc_fire) begin
            slot_d[alloc_idx] = '{valid: 1'b1, ready: 1'b0, exc: 1'b0, misp: 1'b0,
                                  kind: alloc_kind, dest: alloc_dest, value: '0};
        end
        if (flush) begin
            for (int i = 0; i < DEPTH; i++) begin
                slot_d[i].valid = 1'b0;
                slot_d[i].ready = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign lk_value = slot_q[lk_tag].value;
    assign lk_ready = slot_q[lk_tag].valid & slot_q[lk_tag].ready;

    for (genvar g = 0; g < RETIRE_LANES; g++) begin : g_lane
        assign h_valid[g] = slot_q[lane_idx[g]].valid;
        assign h_ready[g] = slot_q[lane_idx[g]].ready;
        assign h_exc[g]   = slot_q[lane_idx[g]].exc;
        assign h_misp[g]  = slot_q[lane_idx[g]].misp;
        assign h_kind[g]  = slot_q[lane_idx[g]].kind;
        assign h_dest[g]  = slot_q[lane_idx[g]].dest;
        assign h_value[g] = slot_q[lane_idx[g]].value;
    end

    // R3: a broadcast to a live slot leaves it complete on the next cycle
    a_r3_result_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (cdb_valid && slot_q[cdb_tag].valid && !flush &&
         !(alloc_fire && alloc_idx == cdb_tag))
        |=> slot_q[$past(cdb_tag)].ready);

    // R4: a resolution records the branch outcome in its slot
    a_r4_branch_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && slot_q[br_tag].valid && !flush &&
         !(alloc_fire && alloc_idx == br_tag))
        |=> slot_q[$past(br_tag)].misp == $past(br_mispredict));

endmodule

// File: rtl/rob_commit_sel.sv
module rob_commit_sel
    import rob_pkg::*;
#(
    parameter int unsigned DEST_W = 16,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 4
) (
    input  logic [CNT_W-1:0]                    count,
    input  logic [RETIRE_LANES-1:0]             h_valid,
    input  logic [RETIRE_LANES-1:0]             h_ready,
    input  logic [RETIRE_LANES-1:0]             h_exc,
    input  logic [RETIRE_LANES-1:0]             h_misp,
    input  rob_kind_e [RETIRE_LANES-1:0]        h_kind,
    input  logic [RETIRE_LANES-1:0][DEST_W-1:0] h_dest,
    input  logic [RETIRE_LANES-1:0][DATA_W-1:0] h_value,
    output logic [1:0]                          retire_cnt,
    output logic [RETIRE_LANES-1:0]             reg_we,
    output logic [RETIRE_LANES-1:0][DEST_W-1:0] reg_idx,
    output logic [RETIRE_LANES-1:0][DATA_W-1:0] reg_data,
    output logic [RETIRE_LANES-1:0]             mem_we,
    output logic [RETIRE_LANES-1:0][DEST_W-1:0] mem_addr,
    output logic [RETIRE_LANES-1:0][DATA_W-1:0] mem_data,
    output logic                                flush,
    output logic [DATA_W-1:0]                   redirect_pc,
    output logic                                exc_raise
);

    logic [RETIRE_LANES-1:0] lane_go;
    logic                    oldest_done;
    logic                    second_clean;

    always_comb begin
        oldest_done  = (count != '0) && h_valid[0] && h_ready[0];
        second_clean = (count >= CNT_W'(2)) && h_valid[1] && h_ready[1] && !h_exc[1] &&
                       !(h_kind[1] == KIND_BRANCH && h_misp[1]);
        lane_go      = '0;
        retire_cnt   = 2'd0;
        flush        = 1'b0;
        exc_raise    = 1'b0;
        redirect_pc  = '0;
        if (oldest_done) begin
            if (h_exc[0]) begin
                flush     = 1'b1;
                exc_raise = 1'b1;
            end else if (h_kind[0] == KIND_BRANCH && h_misp[0]) begin
                flush       = 1'b1;
                redirect_pc = h_value[0];
            end else begin
                lane_go[0] = 1'b1;
                retire_cnt = 2'd1;
                if (second_clean) begin
                    lane_go[1] = 1'b1;
                    retire_cnt = 2'd2;
                end
            end
        end
    end

    always_comb begin
        reg_we   = '0;
        mem_we   = '0;
        reg_idx  = '0;
        reg_data = '0;
        mem_addr = '0;
        mem_data = '0;
        for (int l = 0; l < RETIRE_LANES; l++) begin
            if (lane_go[l]) begin
                case (h_kind[l])
                    KIND_REG: begin
                        reg_we[l]   = 1'b1;
                        reg_idx[l]  = h_dest[l];
                        reg_data[l] = h_value[l];
                    end
                    KIND_STORE: begin
                        mem_we[l]   = 1'b1;
                        mem_addr[l] = h_dest[l];
                        mem_data[l] = h_value[l];
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/rob_core.sv
module rob_core
    import rob_pkg::*;
#(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned DEST_W = 16,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned TAG_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   alloc_req,
    input  logic [1:0]             alloc_kind,
    input  logic [DEST_W-1:0]      alloc_dest,
    input  logic                   rs_free,
    output logic                   alloc_grant,
    output logic [TAG_W-1:0]       alloc_tag,
    input  logic                   cdb_valid,
    input  logic [TAG_W-1:0]       cdb_tag,
    input  logic [DATA_W-1:0]      cdb_value,
    input  logic                   cdb_exc,
    input  logic                   br_valid,
    input  logic [TAG_W-1:0]       br_tag,
    input  logic                   br_mispredict,
    input  logic [DATA_W-1:0]      br_target,
    input  logic [TAG_W-1:0]       lookup_tag,
    output logic [DATA_W-1:0]      lookup_value,
    output logic                   lookup_ready,
    output logic [1:0]             reg_wr_en,
    output logic [1:0][DEST_W-1:0] reg_wr_idx,
    output logic [1:0][DATA_W-1:0] reg_wr_data,
    output logic [1:0]             mem_wr_en,
    output logic [1:0][DEST_W-1:0] mem_wr_addr,
    output logic [1:0][DATA_W-1:0] mem_wr_data,
    output logic                   flush,
    output logic [DATA_W-1:0]      redirect_pc,
    output logic                   exc_raise,
    output logic [TAG_W-1:0]       exc_tag
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [TAG_W-1:0]  head_w, tail_w;
    logic [CNT_W-1:0]  count_w;
    logic [1:0]        retire_w;
    logic              flush_w;

    logic [RETIRE_LANES-1:0]              h_valid, h_ready, h_exc, h_misp;
    rob_kind_e [RETIRE_LANES-1:0]         h_kind;
    logic [RETIRE_LANES-1:0][DEST_W-1:0]  h_dest;
    logic [RETIRE_LANES-1:0][DATA_W-1:0]  h_value;

    assign alloc_grant = alloc_req && rs_free && (count_w != FULL_CNT) && !flush_w;
    assign alloc_tag   = tail_w;
    assign exc_tag     = head_w;
    assign flush       = flush_w;

    rob_ptrs #(.DEPTH(DEPTH), .PTR_W(TAG_W), .CNT_W(CNT_W)) u_ptrs (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_fire (alloc_grant),
        .retire_cnt (retire_w),
        .flush      (flush_w),
        .head_o     (head_w),
        .tail_o     (tail_w),
        .count_o    (count_w)
    );

    rob_entries #(.DEPTH(DEPTH), .PTR_W(TAG_W), .DEST_W(DEST_W), .DATA_W(DATA_W)) u_slots (
        .clk           (clk),
        .rst_n         (rst_n),
        .alloc_fire    (alloc_grant),
        .alloc_idx     (tail_w),
        .alloc_kind    (rob_kind_e'(alloc_kind)),
        .alloc_dest    (alloc_dest),
        .cdb_valid     (cdb_valid),
        .cdb_tag       (cdb_tag),
        .cdb_value     (cdb_value),
        .cdb_exc       (cdb_exc),
        .br_valid      (br_valid),
        .br_tag        (br_tag),
        .br_mispredict (br_mispredict),
        .br_target     (br_target),
        .retire_cnt    (retire_w),
        .head_idx      (head_w),
        .flush         (flush_w),
        .lk_tag        (lookup_tag),
        .lk_value      (lookup_value),
        .lk_ready      (lookup_ready),
        .h_valid       (h_valid),
        .h_ready       (h_ready),
        .h_exc         (h_exc),
        .h_misp        (h_misp),
        .h_kind        (h_kind),
        .h_dest        (h_dest),
        .h_value       (h_value)
    );

    rob_commit_sel #(.DEST_W(DEST_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_retire (
        .count       (count_w),
        .h_valid     (h_valid),
        .h_ready     (h_ready),
        .h_exc       (h_exc),
        .h_misp      (h_misp),
        .h_kind      (h_kind),
        .h_dest      (h_dest),
        .h_value     (h_value),
        .retire_cnt  (retire_w),
        .reg_we      (reg_wr_en),
        .reg_idx     (reg_wr_idx),
        .reg_data    (reg_wr_data),
        .mem_we      (mem_wr_en),
        .mem_addr    (mem_wr_addr),
        .mem_data    (mem_wr_data),
        .flush       (flush_w),
        .redirect_pc (redirect_pc),
        .exc_raise   (exc_raise)
    );

    // R6: lane 0 only writes for a slot that the storage reports complete
    a_r6_write_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en[0] || mem_wr_en[0]) |-> (h_valid[0] && h_ready[0]));

    // R7: lane 1 never writes unless two slots retire together
    a_r7_lane1_in_order: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en[1] || mem_wr_en[1]) |-> (retire_w == 2'd2));

    // R8: after any flush the buffer restarts at slot 0
    a_r8_flush_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        flush_w |=> (alloc_tag == '0 && !lookup_ready));

    // R9: a fault is only taken from the oldest slot once it carries the flag
    a_r9_fault_at_head: assert property (@(posedge clk) disable iff (!rst_n)
        exc_raise |-> (h_valid[0] && h_exc[0] && reg_wr_en == '0 && mem_wr_en == '0));

    // R11: no slot is reserved while the buffer is being emptied
    a_r11_no_grant_on_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flush_w |-> !alloc_grant);

endmodule

// File: tb/rob_core_test.sv
`timescale 1ns/1ps
module rob_core_test;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              alloc_req = 1'b0;
    logic [1:0]        alloc_kind = '0;
    logic [15:0]       alloc_dest = '0;
    logic              rs_free = 1'b1;
    logic              alloc_grant;
    logic [2:0]        alloc_tag;
    logic              cdb_valid = 1'b0;
    logic [2:0]        cdb_tag = '0;
    logic [31:0]       cdb_value = '0;
    logic              cdb_exc = 1'b0;
    logic              br_valid = 1'b0;
    logic [2:0]        br_tag = '0;
    logic              br_mispredict = 1'b0;
    logic [31:0]       br_target = '0;
    logic [2:0]        lookup_tag = '0;
    logic [31:0]       lookup_value;
    logic              lookup_ready;
    logic [1:0]        reg_wr_en;
    logic [1:0][15:0]  reg_wr_idx;
    logic [1:0][31:0]  reg_wr_data;
    logic [1:0]        mem_wr_en;
    logic [1:0][15:0]  mem_wr_addr;
    logic [1:0][31:0]  mem_wr_data;
    logic              flush;
    logic [31:0]       redirect_pc;
    logic              exc_raise;
    logic [2:0]        exc_tag;

    always #4 clk = ~clk;

    rob_core uut (
        .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_kind(alloc_kind),
        .alloc_dest(alloc_dest), .rs_free(rs_free), .alloc_grant(alloc_grant),
        .alloc_tag(alloc_tag), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
        .cdb_value(cdb_value), .cdb_exc(cdb_exc), .br_valid(br_valid), .br_tag(br_tag),
        .br_mispredict(br_mispredict), .br_target(br_target), .lookup_tag(lookup_tag),
        .lookup_value(lookup_value), .lookup_ready(lookup_ready), .reg_wr_en(reg_wr_en),
        .reg_wr_idx(reg_wr_idx), .reg_wr_data(reg_wr_data), .mem_wr_en(mem_wr_en),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .flush(flush),
        .redirect_pc(redirect_pc), .exc_raise(exc_raise), .exc_tag(exc_tag)
    );

    // behavioural reference: program-order queue of tags plus per-tag records
    int          order_q[$];
    int          next_tag;
    logic [1:0]  m_kind [8];
    logic [15:0] m_dest [8];
    logic [31:0] m_val  [8];
    bit          m_live [8];
    bit          m_done [8];
    bit          m_exc  [8];
    bit          m_misp [8];

    int n_chk  = 0;
    int n_fail = 0;
    int lk_sel = 0;

    logic [1:0]       e_rw, e_mw;
    logic [1:0][15:0] e_ra, e_ma;
    logic [1:0][31:0] e_rd, e_md;
    bit               e_fl, e_ex, e_gnt;
    int               e_ret, e_extag;
    logic [31:0]      e_redir;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        alloc_req = 1'b0; cdb_valid = 1'b0; cdb_exc = 1'b0;
        br_valid = 1'b0; br_mispredict = 1'b0; rs_free = 1'b1;
    endtask

    task automatic req_slot(input logic [1:0] k, input logic [15:0] d);
        alloc_req = 1'b1; alloc_kind = k; alloc_dest = d;
    endtask

    task automatic post(input int t, input logic [31:0] v, input bit x);
        cdb_valid = 1'b1; cdb_tag = 3'(t); cdb_value = v; cdb_exc = x;
    endtask

    task automatic resolve(input int t, input bit m, input logic [31:0] tgt);
        br_valid = 1'b1; br_tag = 3'(t); br_mispredict = m; br_target = tgt;
    endtask

    task automatic lane_expect(input int l, input int t);
        if (m_kind[t] == 2'd0) begin
            e_rw[l] = 1'b1; e_ra[l] = m_dest[t]; e_rd[l] = m_val[t];
        end else if (m_kind[t] == 2'd1) begin
            e_mw[l] = 1'b1; e_ma[l] = m_dest[t]; e_md[l] = m_val[t];
        end
    endtask

    task automatic cycle();
        int cnt, h0, h1, lt;
        lookup_tag = 3'(lk_sel % 8);
        lk_sel++;
        #1;
        cnt = order_q.size();
        e_rw = '0; e_mw = '0; e_ra = '0; e_ma = '0; e_rd = '0; e_md = '0;
        e_fl = 0; e_ex = 0; e_ret = 0; e_extag = 0; e_redir = '0;
        if (cnt > 0) begin
            h0 = order_q[0];
            if (m_done[h0]) begin
                if (m_exc[h0]) begin
                    e_fl = 1; e_ex = 1; e_extag = h0;
                end else if (m_kind[h0] == 2'd2 && m_misp[h0]) begin
                    e_fl = 1; e_redir = m_val[h0];
                end else begin
                    e_ret = 1; lane_expect(0, h0);
                    if (cnt > 1) begin
                        h1 = order_q[1];
                        if (m_done[h1] && !m_exc[h1] && !(m_kind[h1] == 2'd2 && m_misp[h1])) begin
                            e_ret = 2; lane_expect(1, h1);
                        end
                    end
                end
            end
        end
        e_gnt = alloc_req && rs_free && (cnt < 8) && !e_fl;

        chk(e_fl ? "R11" : "R2", "alloc_grant", 64'(alloc_grant), 64'(e_gnt));
        if (e_gnt) chk("R2", "alloc_tag", 64'(alloc_tag), 64'(next_tag));
        chk("R5/R6", "reg_wr_en[0]", 64'(reg_wr_en[0]), 64'(e_rw[0]));
        chk("R7", "reg_wr_en[1]", 64'(reg_wr_en[1]), 64'(e_rw[1]));
        chk("R1/R5", "mem_wr_en", 64'(mem_wr_en), 64'(e_mw));
        for (int l = 0; l < 2; l++) begin
            if (e_rw[l]) begin
                chk("R1", "reg_wr_idx", 64'(reg_wr_idx[l]), 64'(e_ra[l]));
                chk("R3/R5", "reg_wr_data", 64'(reg_wr_data[l]), 64'(e_rd[l]));
            end
            if (e_mw[l]) begin
                chk("R1", "mem_wr_addr", 64'(mem_wr_addr[l]), 64'(e_ma[l]));
                chk("R3/R5", "mem_wr_data", 64'(mem_wr_data[l]), 64'(e_md[l]));
            end
        end
        chk("R8", "flush", 64'(flush), 64'(e_fl));
        chk("R9", "exc_raise", 64'(exc_raise), 64'(e_ex));
        if (e_ex) chk("R9", "exc_tag", 64'(exc_tag), 64'(e_extag));
        if (e_fl) chk("R4/R8", "redirect_pc", 64'(redirect_pc), 64'(e_redir));
        lt = int'(lookup_tag);
        chk("R10", "lookup_ready", 64'(lookup_ready), 64'(m_live[lt] && m_done[lt]));
        if (m_live[lt] && m_done[lt])
            chk("R3/R10", "lookup_value", 64'(lookup_value), 64'(m_val[lt]));

        @(posedge clk);
        if (cdb_valid && m_live[cdb_tag]) begin
            m_val[cdb_tag] = cdb_value; m_done[cdb_tag] = 1; m_exc[cdb_tag] = cdb_exc;
        end
        if (br_valid && m_live[br_tag]) begin
            m_val[br_tag] = br_target; m_done[br_tag] = 1; m_misp[br_tag] = br_mispredict;
        end
        if (e_fl) begin
            for (int i = 0; i < 8; i++) m_live[i] = 0;
            order_q.delete();
            next_tag = 0;
        end else begin
            for (int r = 0; r < e_ret; r++) begin
                m_live[order_q[0]] = 0;
                void'(order_q.pop_front());
            end
            if (e_gnt) begin
                m_live[next_tag] = 1; m_done[next_tag] = 0; m_exc[next_tag] = 0;
                m_misp[next_tag] = 0; m_kind[next_tag] = alloc_kind;
                m_dest[next_tag] = alloc_dest; m_val[next_tag] = '0;
                order_q.push_back(next_tag);
                next_tag = (next_tag + 1) % 8;
            end
        end
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [1:0] kinds [8];
        kinds = '{2'd0, 2'd1, 2'd0, 2'd2, 2'd0, 2'd0, 2'd2, 2'd0};
        next_tag = 0;
        for (int i = 0; i < 8; i++) begin
            m_live[i] = 0; m_done[i] = 0; m_exc[i] = 0; m_misp[i] = 0;
            m_kind[i] = '0; m_dest[i] = '0; m_val[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        cycle(); cycle();                           // reset state, R10 empty lookups

        for (int i = 0; i < 8; i++) begin           // fill the buffer, R2
            idle(); req_slot(kinds[i], 16'h100 + 16'(i)); cycle();
        end
        idle(); req_slot(2'd0, 16'h1ff); cycle();   // full, R2 refuses

        idle(); post(2, 32'hA2, 0); cycle();        // out of order, R6 no write
        idle(); post(1, 32'hA1, 0); req_slot(2'd0, 16'h1fe); cycle();
        idle(); post(0, 32'hA0, 0); cycle();
        idle(); resolve(3, 0, 32'h40); req_slot(2'd0, 16'h120); cycle(); // R7 dual retire
        idle(); post(5, 32'hA5, 1); req_slot(2'd1, 16'h121); cycle();
        idle(); post(4, 32'hA4, 0); cycle();
        idle(); req_slot(2'd0, 16'h122); cycle();   // R9 fault held on lane 1
        idle(); req_slot(2'd0, 16'h123); cycle();   // R9 fault at head, R11
        idle(); cycle();

        idle(); req_slot(2'd2, 16'h300); cycle();   // R8 restart at tag 0
        idle(); req_slot(2'd0, 16'h301); cycle();
        idle(); req_slot(2'd1, 16'h302); cycle();
        idle(); post(1, 32'hB1, 0); resolve(0, 1, 32'h1234); cycle();
        idle(); req_slot(2'd0, 16'h303); cycle();   // R8 flush, R11 refused
        idle(); req_slot(2'd0, 16'h400); rs_free = 1'b0; cycle(); // R2 no station
        idle(); cycle();

        for (int n = 0; n < 3000; n++) begin        // mixed traffic
            idle();
            if ($urandom_range(0, 3) != 0) begin
                req_slot(2'($urandom_range(0, 3)), 16'($urandom));
                rs_free = ($urandom_range(0, 7) != 0);
            end
            if (order_q.size() > 0) begin
                int t;
                t = order_q[$urandom_range(0, order_q.size() - 1)];
                if (!m_done[t] && m_kind[t] != 2'd2)
                    post(t, $urandom, $urandom_range(0, 31) == 0);
                t = order_q[$urandom_range(0, order_q.size() - 1)];
                if (!m_done[t] && m_kind[t] == 2'd2 && $urandom_range(0, 1) == 1)
                    resolve(t, $urandom_range(0, 7) == 0, $urandom);
            end
            cycle();
        end
        idle();
        cycle();
        finish_run();
    end

endmodule